// File: doc/BRIEF.md
# Configuration Access Bridge

This unit lets a host processor reach the configuration registers of the devices attached below it, using two port-mapped registers. The processor first writes a selector word that names an enable flag, a bus, a device, a function and a dword offset. It then reads or writes a data port. The bridge forwards that access to the chosen slot. It raises that slot's select line together with a request, and it holds the processor waiting until the target acknowledges or a fixed response window runs out.

A missing target is turned into a master abort, and a read that aborts completes with all-ones data. Software can therefore probe offset 0, function 0 of every device number: an all-ones vendor field means the slot is empty. A cleared enable flag, a bus number other than zero, or a device number with no select line aborts at once, without any transaction on the device side. Byte enables reach the target unchanged, so a write can update part of a dword.

Top module: `cfgx_bridge`

## Requirements
- R1: After reset `host_ready`, `dev_req` and every `dev_sel` bit are low, and the selector register reads back as zero.
- R2: A dword access whose port address, with bits 1:0 masked, equals `ADDR_PORT` (default 0xCF8) reaches the selector register. Host byte lane i (bits 8i+7:8i) is written only when `host_be[i]` is set. Layout: bit 31 enable, bits 23:16 bus, bits 15:11 device, bits 10:8 function, bits 7:2 dword offset. Bits 30:24 and 1:0 always read as zero. `host_ready` pulses in the cycle after the request.
- R3: While an access is forwarded, `dev_req` is high and exactly one `dev_sel` bit is set: the bit whose index equals the device field. `dev_func` carries the function field and `dev_reg` carries the dword offset.
- R4: An access to `DATA_PORT` (default 0xCFC) is forwarded when enable is 1, bus is 0 and device is below `NUM_SLOTS`. `dev_we`, `dev_be` and `dev_wdata` carry the host's direction, byte enables and write data. Every write completion returns zero on `host_rdata`.
- R5: If `dev_ack` is high in the k-th cycle of `dev_req` (k from 1 to `TIMEOUT`), `dev_req` is low in the next cycle. In that same next cycle `host_ready` pulses, and for a read `host_rdata` holds the `dev_rdata` value that came with the acknowledge.
- R6: If no acknowledge arrives, `dev_req` stays high for exactly `TIMEOUT` cycles. In the following cycle `host_ready` pulses and a read returns 0xFFFFFFFF.
- R7: An acknowledge in the last cycle of the window (k = `TIMEOUT`) completes as a normal response with the target's data, not as a timeout.
- R8: With the enable bit clear, a data-port access is not forwarded. `host_ready` pulses in the next cycle, a read returns 0xFFFFFFFF and a write has no effect on the device side.
- R9: A nonzero bus field aborts a data-port access in the same way as R8.
- R10: A device field of `NUM_SLOTS` or higher aborts a data-port access in the same way as R8, with no select line raised.
- R11: An access to any other port address completes in the next cycle with zero read data. It leaves the selector register unchanged and raises no device request.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Single-cycle access request from the processor |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | PORT_AW | Port address of the access |
| host_be | input | 4 | Byte enables |
| host_wdata | input | 32 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ready |
| dev_req | output | 1 | Configuration request toward the devices, held until done |
| dev_sel | output | NUM_SLOTS | One-hot slot select |
| dev_we | output | 1 | Direction of the forwarded access |
| dev_func | output | 3 | Function number |
| dev_reg | output | 6 | Dword offset within the 256-byte space |
| dev_be | output | 4 | Forwarded byte enables |
| dev_wdata | output | 32 | Forwarded write data |
| dev_ack | input | 1 | Target response |
| dev_rdata | input | 32 | Target read data, valid with dev_ack |

## Verification
Two outcomes can fall in the same cycle: the target's acknowledge and the expiry of the response window, when the acknowledge arrives in the last permitted cycle. The bench provokes this with a target model that answers after exactly `TIMEOUT` request cycles. It also provokes the neighbouring cases, one cycle earlier and never. It judges the outcome by the completion cycle, the number of request cycles seen, and whether the returned data is the target's word or all-ones.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned BE_W   = WORD_W / 8;
  localparam logic [WORD_W-1:0] ALL_ONES = '1;

  // Decoded selector register contents
  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
    logic [5:0] dwo;
  } cfg_sel_t;

  typedef enum logic {ST_IDLE, ST_WAIT} txn_st_e;

  function automatic cfg_sel_t sel_from_word(input logic [WORD_W-1:0] w);
    cfg_sel_t s;
    s.en   = w[31];
    s.bus  = w[23:16];
    s.dev  = w[15:11];
    s.func = w[10:8];
    s.dwo  = w[7:2];
    return s;
  endfunction

  function automatic logic [WORD_W-1:0] sel_to_word(input cfg_sel_t s);
    return {s.en, 7'b0, s.bus, s.dev, s.func, s.dwo, 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [BE_W-1:0]   be);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int i = 0; i < int'(BE_W); i++) begin
      if (be[i]) r[8*i +: 8] = new_w[8*i +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/cfgx_addr_reg.sv
module cfgx_addr_reg
  import cfgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   be,
  input  logic [WORD_W-1:0] wdata,
  output cfg_sel_t          sel,
  output logic [WORD_W-1:0] rd_word
);

  cfg_sel_t sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (wr_en) begin
      sel_q <= sel_from_word(lane_merge(sel_to_word(sel_q), wdata, be));
    end
  end

  assign sel     = sel_q;
  assign rd_word = sel_to_word(sel_q);

endmodule

// File: rtl/cfgx_slot_decode.sv
module cfgx_slot_decode #(
  parameter int unsigned NUM_SLOTS = 8
) (
  input  logic                 active,
  input  logic [4:0]           dev,
  output logic [NUM_SLOTS-1:0] sel,
  output logic                 present
);

  generate
    for (genvar i = 0; i < int'(NUM_SLOTS); i++) begin : g_slot
      assign sel[i] = active && (dev == 5'(i));
    end
  endgenerate

  assign present = (32'(dev) < NUM_SLOTS);

endmodule

// File: rtl/cfgx_txn_ctrl.sv
module cfgx_txn_ctrl
  import cfgx_pkg::*;
#(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [BE_W-1:0]   host_be,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              hit_addr,
  input  logic              hit_data,
  input  logic              route_ok,
  input  logic [WORD_W-1:0] addr_word,
  input  logic              dev_ack,
  input  logic [WORD_W-1:0] dev_rdata,
  output logic              busy,
  output logic              accept,
  output logic              addr_wr,
  output logic              host_ready,
  output logic [WORD_W-1:0] host_rdata,
  output logic              lat_we,
  output logic [BE_W-1:0]   lat_be,
  output logic [WORD_W-1:0] lat_wdata,
  output logic              fwd_start,
  output logic              abort_now,
  output logic              ack_take,
  output logic              tmo_fire
);

  localparam int unsigned CW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);

  txn_st_e           st_q;
  logic [CW-1:0]     cnt_q;
  logic              ready_q;
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] rd_nxt;
  logic              is_data;

  assign busy      = (st_q == ST_WAIT);
  assign accept    = host_req && (st_q == ST_IDLE);
  assign is_data   = accept && hit_data;
  assign fwd_start = is_data && route_ok;
  assign abort_now = is_data && !route_ok;
  assign addr_wr   = accept && hit_addr && host_we;
  assign ack_take  = busy && dev_ack;
  assign tmo_fire  = busy && !dev_ack && (cnt_q == CNT_LAST);

  always_comb begin
    rd_nxt = '0;
    if (accept && hit_addr && !host_we)  rd_nxt = addr_word;
    else if (abort_now && !host_we)      rd_nxt = ALL_ONES;
    else if (ack_take && !lat_we)        rd_nxt = dev_rdata;
    else if (tmo_fire && !lat_we)        rd_nxt = ALL_ONES;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      ready_q   <= 1'b0;
      rdata_q   <= '0;
      lat_we    <= 1'b0;
      lat_be    <= '0;
      lat_wdata <= '0;
    end else begin
      ready_q <= (accept && !fwd_start) || ack_take || tmo_fire;
      rdata_q <= rd_nxt;
      if (fwd_start) begin
        st_q      <= ST_WAIT;
        cnt_q     <= '0;
        lat_we    <= host_we;
        lat_be    <= host_be;
        lat_wdata <= host_we ? host_wdata : '0;
      end else if (ack_take || tmo_fire) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
      end else if (busy) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign host_ready = ready_q;
  assign host_rdata = rdata_q;

endmodule

// File: rtl/cfgx_bridge.sv
module cfgx_bridge
  import cfgx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned TIMEOUT   = 16,
  parameter int unsigned PORT_AW   = 16,
  parameter logic [PORT_AW-1:0] ADDR_PORT = PORT_AW'(16'h0CF8),
  parameter logic [PORT_AW-1:0] DATA_PORT = PORT_AW'(16'h0CFC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_req,
  input  logic                 host_we,
  input  logic [PORT_AW-1:0]   host_addr,
  input  logic [3:0]           host_be,
  input  logic [31:0]          host_wdata,
  output logic                 host_ready,
  output logic [31:0]          host_rdata,
  output logic                 dev_req,
  output logic [NUM_SLOTS-1:0] dev_sel,
  output logic                 dev_we,
  output logic [2:0]           dev_func,
  output logic [5:0]           dev_reg,
  output logic [3:0]           dev_be,
  output logic [31:0]          dev_wdata,
  input  logic                 dev_ack,
  input  logic [31:0]          dev_rdata
);

  localparam logic [PORT_AW-1:0] DW_MASK = ~PORT_AW'(3);

  // Named internal events, also observed by the bound checker
  logic              hit_addr, hit_data, route_ok, slot_present;
  logic              busy, accept, addr_wr;
  logic              fwd_start, abort_now, ack_take, tmo_fire;
  cfg_sel_t          sel;
  logic [WORD_W-1:0] addr_word;

  assign hit_addr = ((host_addr & DW_MASK) == (ADDR_PORT & DW_MASK));
  assign hit_data = ((host_addr & DW_MASK) == (DATA_PORT & DW_MASK));
  assign route_ok = sel.en && (sel.bus == 8'd0) && slot_present;

  cfgx_addr_reg u_areg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (addr_wr),
    .be      (host_be),
    .wdata   (host_wdata),
    .sel     (sel),
    .rd_word (addr_word)
  );

  cfgx_slot_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
    .active  (busy),
    .dev     (sel.dev),
    .sel     (dev_sel),
    .present (slot_present)
  );

  cfgx_txn_ctrl #(.TIMEOUT(TIMEOUT)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_be    (host_be),
    .host_wdata (host_wdata),
    .hit_addr   (hit_addr),
    .hit_data   (hit_data),
    .route_ok   (route_ok),
    .addr_word  (addr_word),
    .dev_ack    (dev_ack),
    .dev_rdata  (dev_rdata),
    .busy       (busy),
    .accept     (accept),
    .addr_wr    (addr_wr),
    .host_ready (host_ready),
    .host_rdata (host_rdata),
    .lat_we     (dev_we),
    .lat_be     (dev_be),
    .lat_wdata  (dev_wdata),
    .fwd_start  (fwd_start),
    .abort_now  (abort_now),
    .ack_take   (ack_take),
    .tmo_fire   (tmo_fire)
  );

  assign dev_req  = busy;
  assign dev_func = sel.func;
  assign dev_reg  = sel.dwo;

endmodule

// File: rtl/cfgx_bridge_chk.sv
module cfgx_bridge_chk #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned TIMEOUT   = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 host_we,
  input logic                 host_ready,
  input logic [31:0]          host_rdata,
  input logic                 dev_req,
  input logic [NUM_SLOTS-1:0] dev_sel,
  input logic                 dev_we,
  input logic                 dev_ack,
  input logic [31:0]          dev_rdata,
  input logic                 accept,
  input logic                 hit_addr,
  input logic                 abort_now,
  input logic                 ack_take,
  input logic                 tmo_fire
);

  logic [31:0] win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       win_cnt <= '0;
    else if (dev_req) win_cnt <= win_cnt + 1;
    else              win_cnt <= '0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_req |-> (dev_sel == '0));

  assert_addr_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit_addr && !host_we) |=>
      (host_ready && host_rdata[30:24] == 7'd0 && host_rdata[1:0] == 2'd0));

  assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |-> ($countones(dev_sel) == 1));

  assert_ack_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !dev_we) |=> (host_ready && !dev_req && host_rdata == $past(dev_rdata)));

  assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && dev_ack) |=> (!dev_req && host_ready));

  assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |-> (win_cnt < TIMEOUT));

  assert_tmo_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_fire && !dev_we) |=> (host_ready && host_rdata == 32'hFFFF_FFFF));

  assert_abort_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_now && !host_we) |=> (host_ready && !dev_req && host_rdata == 32'hFFFF_FFFF));

  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_now |=> !dev_req);

endmodule

bind cfgx_bridge cfgx_bridge_chk #(.NUM_SLOTS(NUM_SLOTS), .TIMEOUT(TIMEOUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_we    (host_we),
  .host_ready (host_ready),
  .host_rdata (host_rdata),
  .dev_req    (dev_req),
  .dev_sel    (dev_sel),
  .dev_we     (dev_we),
  .dev_ack    (dev_ack),
  .dev_rdata  (dev_rdata),
  .accept     (accept),
  .hit_addr   (hit_addr),
  .abort_now  (abort_now),
  .ack_take   (ack_take),
  .tmo_fire   (tmo_fire)
);

// File: tb/sim_cfgx_bridge.sv
module sim_cfgx_bridge;

  localparam int NS  = 8;
  localparam int TMO = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_req = 1'b0, host_we = 1'b0;
  logic [15:0]   host_addr = '0;
  logic [3:0]    host_be = '0;
  logic [31:0]   host_wdata = '0;
  logic          host_ready;
  logic [31:0]   host_rdata;
  logic          dev_req;
  logic [NS-1:0] dev_sel;
  logic          dev_we;
  logic [2:0]    dev_func;
  logic [5:0]    dev_reg;
  logic [3:0]    dev_be;
  logic [31:0]   dev_wdata;
  logic          dev_ack = 1'b0;
  logic [31:0]   dev_rdata = '0;

  always #4 clk = ~clk;

  cfgx_bridge #(.NUM_SLOTS(NS), .TIMEOUT(TMO)) u0 (.*);

  int vectors = 0;
  int errors  = 0;

  // Results of the last access
  logic [31:0]   r_rd;
  int            r_n, r_reqc;
  logic [NS-1:0] r_sel;
  logic          r_we, r_req_end;
  logic [3:0]    r_be;
  logic [31:0]   r_wd;
  logic [2:0]    r_func;
  logic [5:0]    r_reg;

  // Bench model of the selector register
  logic [31:0] model_sel = '0;

  function automatic logic [31:0] keep_fields(input logic [31:0] w);
    return w & 32'h80FF_FFFC;
  endfunction

  function automatic logic [31:0] bytes_in(input logic [31:0] o, input logic [31:0] n,
                                           input logic [3:0] be);
    logic [31:0] m;
    m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return (o & ~m) | (n & m);
  endfunction

  function automatic logic will_forward(input logic [31:0] s);
    return s[31] && (s[23:16] == 8'd0) && (int'(s[15:11]) < NS);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [15:0] pa, input logic [3:0] be,
                        input logic [31:0] wd, input int lat, input logic [31:0] trd);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = pa; host_be = be; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    r_n = 1; r_reqc = 0; r_sel = '0; r_we = 1'b0; r_be = '0; r_wd = '0; r_func = '0; r_reg = '0;
    while (!host_ready && r_n < 4 * TMO) begin
      if (dev_req) begin
        r_reqc++;
        if (r_reqc == 1) begin
          r_sel = dev_sel; r_we = dev_we; r_be = dev_be; r_wd = dev_wdata;
          r_func = dev_func; r_reg = dev_reg;
        end
        if (r_reqc == lat) begin dev_ack = 1'b1; dev_rdata = trd; end
      end
      @(negedge clk);
      dev_ack = 1'b0; dev_rdata = $urandom;
      r_n++;
    end
    r_rd = host_rdata; r_req_end = dev_req;
  endtask

  task automatic sel_write(input logic [31:0] w, input logic [3:0] be);
    access(1'b1, 16'h0CF8, be, w, 0, 32'h0);
    model_sel = keep_fields(bytes_in(model_sel, w, be));
    chk("R2 selector write completion cycle", 32'(r_n), 32'd1);
  endtask

  // Data-port access checked against the bench model
  task automatic data_check(input logic we, input logic [3:0] be, input logic [31:0] wd,
                            input int lat, input logic [31:0] trd);
    logic ok;
    ok = will_forward(model_sel);
    access(we, 16'h0CFC, be, wd, lat, trd);
    if (ok) begin
      chk("R3 one-hot select", 32'(r_sel), 32'(1) << model_sel[15:11]);
      chk("R3 function", 32'(r_func), 32'(model_sel[10:8]));
      chk("R3 dword offset", 32'(r_reg), 32'(model_sel[7:2]));
      chk("R4 direction", 32'(r_we), 32'(we));
      chk("R4 byte enables", 32'(r_be), 32'(be));
      if (we) chk("R4 write data", r_wd, wd);
      if (lat >= 1 && lat <= TMO) begin
        chk("R5 completion cycle", 32'(r_n), 32'(lat + 1));
        chk("R5 request cycles", 32'(r_reqc), 32'(lat));
        chk("R5 read data", r_rd, we ? 32'h0 : trd);
      end else begin
        chk("R6 completion cycle", 32'(r_n), 32'(TMO + 1));
        chk("R6 request cycles", 32'(r_reqc), 32'(TMO));
        chk("R6 all-ones", r_rd, we ? 32'h0 : 32'hFFFF_FFFF);
      end
      chk("R5 request released", 32'(r_req_end), 32'd0);
    end else begin
      chk("R8 abort completion cycle", 32'(r_n), 32'd1);
      chk("R8 no device request", 32'(r_reqc), 32'd0);
      chk("R8 abort data", r_rd, we ? 32'h0 : 32'hFFFF_FFFF);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", 32'(host_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 request after reset", 32'(dev_req), 32'd0);
    chk("R1 selects after reset", 32'(dev_sel), 32'd0);
    access(1'b0, 16'h0CF8, 4'hF, 32'h0, 0, 32'h0);
    chk("R1 selector reset value", r_rd, 32'h0);
    chk("R2 read completion cycle", 32'(r_n), 32'd1);

    // R2: reserved bits and byte lanes
    sel_write(32'hFFFF_FFFF, 4'hF);
    access(1'b0, 16'h0CF8, 4'hF, 32'h0, 0, 32'h0);
    chk("R2 reserved bits read zero", r_rd, 32'h80FF_FFFC);
    sel_write(32'h0000_1A0C, 4'b0011);
    access(1'b0, 16'h0CF8, 4'hF, 32'h0, 0, 32'h0);
    chk("R2 partial byte write", r_rd, 32'h80FF_1A0C);

    // R3/R4/R5: device 3, function 2, dword 3
    sel_write(32'h8000_1A0C, 4'hF);
    data_check(1'b0, 4'hF, 32'h0, 3, 32'hDEAD_BEEF);
    chk("R3 slot 3 selected", 32'(r_sel), 32'h8);
    data_check(1'b1, 4'b0101, 32'h1234_5678, 1, 32'hAAAA_5555);

    // R7: acknowledge in the last window cycle
    data_check(1'b0, 4'hF, 32'h0, TMO, 32'h0BAD_F00D);
    chk("R7 last-cycle ack keeps data", r_rd, 32'h0BAD_F00D);
    data_check(1'b0, 4'hF, 32'h0, TMO - 1, 32'h1357_9BDF);
    // R6: no acknowledge
    data_check(1'b0, 4'hF, 32'h0, 0, 32'h5555_AAAA);
    chk("R6 empty slot reads all-ones", r_rd, 32'hFFFF_FFFF);

    // R8: enable clear
    sel_write(32'h0000_1A0C, 4'hF);
    data_check(1'b0, 4'hF, 32'h0, 1, 32'h1111_2222);
    data_check(1'b1, 4'hF, 32'hCAFE_0000, 1, 32'h0);
    // R9: nonzero bus
    sel_write(32'h8001_1A0C, 4'hF);
    data_check(1'b0, 4'hF, 32'h0, 1, 32'h3333_4444);
    chk("R9 bus abort all-ones", r_rd, 32'hFFFF_FFFF);
    // R10: device without a select line
    sel_write(32'h8000_4800, 4'hF);
    data_check(1'b0, 4'hF, 32'h0, 1, 32'h6666_7777);
    chk("R10 no slot reads all-ones", r_rd, 32'hFFFF_FFFF);

    // R11: other port addresses
    access(1'b1, 16'h0CF4, 4'hF, 32'hFFFF_FFFF, 1, 32'h0);
    chk("R11 unmapped write completion", 32'(r_n), 32'd1);
    chk("R11 unmapped write no request", 32'(r_reqc), 32'd0);
    access(1'b0, 16'h0D00, 4'hF, 32'h0, 1, 32'h0);
    chk("R11 unmapped read zero", r_rd, 32'h0);
    access(1'b0, 16'h0CF8, 4'hF, 32'h0, 0, 32'h0);
    chk("R11 selector unchanged", r_rd, model_sel);

    // Enumeration-style and random traffic
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 3) begin
        logic [31:0] w;
        w = $urandom;
        w[31] = ($urandom_range(0, 3) != 0);
        if ($urandom_range(0, 3) != 0) w[23:16] = 8'd0;
        if ($urandom_range(0, 3) != 0) w[15:11] = 5'($urandom_range(0, NS - 1));
        sel_write(w, ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'hF);
      end else if (op < 4) begin
        access(1'b0, 16'h0CF8, 4'hF, 32'h0, 0, 32'h0);
        chk("R2 selector readback", r_rd, model_sel);
      end else if (op < 5) begin
        access(1'($urandom), 16'h0CF0, 4'hF, $urandom, 1, 32'h0);
        chk("R11 unmapped data", r_rd, 32'h0);
        chk("R11 unmapped no request", 32'(r_reqc), 32'd0);
      end else begin
        data_check(1'($urandom), 4'($urandom), $urandom, $urandom_range(0, TMO + 2), $urandom);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule